// File: doc/BRIEF.md
# Bidirectional Transceiver Register

This block is an 8-bit data-path cell sitting between two pad groups, called side A and side B. It carries one storage register for each direction. Each register can pass data straight through, hold it, or capture it on a rising edge of that direction's own strobe. One mode input is shared by both directions. When it is high, both registers follow their source side. When it is low, each register only loads on a low-to-high transition of its strobe.

A direction select and a shared active-low drive enable decide which side's pads are driven. Each pad group is modelled as separate input, output and output-enable vectors, so the cell has no internal tri-states. The strobes are ordinary inputs sampled in the system clock domain. Every output is registered and appears one system clock after the inputs that cause it. Data is never inverted.

Top module: `bidir_xcvr_reg`

## Requirements
- R1: While `drive_en_n` is high, `a_pad_oe` and `b_pad_oe` are all zeros one clock later, whatever `dir_a2b` is.
- R2: With `drive_en_n` low, `dir_a2b` = 1 makes `b_pad_oe` all ones and `a_pad_oe` all zeros one clock later. `dir_a2b` = 0 gives the opposite.
- R3: While `pass_en` is high, `b_pad_o` equals the `a_pad_i` value from the previous clock (pass-through mode).
- R4: While `pass_en` is low and `strobe_a2b` keeps a static level, including a static high, `b_pad_o` holds its value.
- R5: While `pass_en` is low, a rising edge of `strobe_a2b` (low in one clock, high in the next) loads that cycle's `a_pad_i`, and it shows on `b_pad_o` one clock later. A falling edge loads nothing.
- R6: The B-to-A register behaves like R3 to R5, using `b_pad_i`, `a_pad_o` and `strobe_b2a`. It ignores `strobe_a2b`.
- R7: Data passes non-inverted in every mode.
- R8: If `pass_en` falls while `strobe_a2b` is already high, the register keeps the value it held just before `pass_en` fell.
- R9: During reset, both registers read zero and both output-enable vectors are all zeros.
- R10: The registers keep loading while the drive enables are off. A value loaded during isolation is shown once the drive is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| drive_en_n | input | 1 | Shared active-low pad drive enable |
| dir_a2b | input | 1 | 1: drive side B, 0: drive side A |
| pass_en | input | 1 | 1: pass-through, 0: edge capture |
| strobe_a2b | input | 1 | Capture strobe for the A-to-B register |
| strobe_b2a | input | 1 | Capture strobe for the B-to-A register |
| a_pad_i | input | 8 | Side A pad input |
| a_pad_o | output | 8 | Side A pad output (B-to-A register) |
| a_pad_oe | output | 8 | Side A pad drive enables |
| b_pad_i | input | 8 | Side B pad input |
| b_pad_o | output | 8 | Side B pad output (A-to-B register) |
| b_pad_oe | output | 8 | Side B pad drive enables |

## Verification
Pass-through is tried with complementary bit patterns (A5/5A), which shows both that data follows the source and that no bit is inverted. Capture mode is driven with the strobe rising, staying high, falling and staying low while the source data keeps changing. This separates a true edge load from a level load and from a load on the falling edge. A case where the mode input drops while the strobe is already high shows that the switch into capture mode does not create a false edge. The B-to-A register is then toggled against the other direction's strobe to show that the two directions are independent. The enable tests cover isolation and both directions, including loading while isolated.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

    typedef enum logic [1:0] {
        ST_PASS = 2'd0,
        ST_HOLD = 2'd1,
        ST_EDGE = 2'd2
    } store_mode_e;

    function automatic store_mode_e pick_mode(input logic pass, input logic rise);
        if (pass)      return ST_PASS;
        else if (rise) return ST_EDGE;
        else           return ST_HOLD;
    endfunction

endpackage

// File: rtl/xcvr_store.sv
module xcvr_store #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pass_en,
    input  logic             strobe,
    input  logic [WIDTH-1:0] src,
    output logic [WIDTH-1:0] held
);
    import xcvr_pkg::*;

    typedef struct packed {
        logic [WIDTH-1:0] data;
        logic             strobe_prev;
    } store_t;

    store_t      st_d, st_q;
    store_mode_e mode;

    always_comb begin
        st_d             = st_q;
        st_d.strobe_prev = strobe;
        mode             = pick_mode(pass_en, strobe & ~st_q.strobe_prev);
        case (mode)
            ST_PASS, ST_EDGE: st_d.data = src;
            default:          st_d.data = st_q.data;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign held = st_q.data;

    // R3: pass-through follows source one clock later
    a_r3_pass_follows: assert property (@(posedge clk) disable iff (!rst_n)
        pass_en |=> (held == $past(src)));

    // R5: rising strobe in capture mode loads the source
    a_r5_edge_loads: assert property (@(posedge clk) disable iff (!rst_n)
        (!pass_en && strobe && !st_q.strobe_prev) |=> (held == $past(src)));

    // R4 / R8: no rising strobe in capture mode keeps the value
    a_r4_hold_static: assert property (@(posedge clk) disable iff (!rst_n)
        (!pass_en && !(strobe && !st_q.strobe_prev)) |=> $stable(held));

endmodule

// File: rtl/xcvr_drive_ctrl.sv
module xcvr_drive_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic drive_en_n,
    input  logic dir_a2b,
    output logic drv_a,
    output logic drv_b
);
    typedef struct packed {
        logic a;
        logic b;
    } drv_t;

    drv_t drv_d, drv_q;

    always_comb begin
        drv_d.a = !drive_en_n && !dir_a2b;
        drv_d.b = !drive_en_n &&  dir_a2b;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) drv_q <= '0;
        else        drv_q <= drv_d;
    end

    assign drv_a = drv_q.a;
    assign drv_b = drv_q.b;

    // R1: isolation disables both sides
    a_r1_isolate: assert property (@(posedge clk) disable iff (!rst_n)
        drive_en_n |=> (!drv_a && !drv_b));

    // R2: direction selects the driven side
    a_r2_drive_b: assert property (@(posedge clk) disable iff (!rst_n)
        (!drive_en_n && dir_a2b) |=> (drv_b && !drv_a));

    a_r2_drive_a: assert property (@(posedge clk) disable iff (!rst_n)
        (!drive_en_n && !dir_a2b) |=> (drv_a && !drv_b));

endmodule

// File: rtl/bidir_xcvr_reg.sv
module bidir_xcvr_reg #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             drive_en_n,
    input  logic             dir_a2b,
    input  logic             pass_en,
    input  logic             strobe_a2b,
    input  logic             strobe_b2a,
    input  logic [WIDTH-1:0] a_pad_i,
    output logic [WIDTH-1:0] a_pad_o,
    output logic [WIDTH-1:0] a_pad_oe,
    input  logic [WIDTH-1:0] b_pad_i,
    output logic [WIDTH-1:0] b_pad_o,
    output logic [WIDTH-1:0] b_pad_oe
);
    logic drv_a, drv_b;

    xcvr_store #(.WIDTH(WIDTH)) u_store_a2b (
        .clk     (clk),
        .rst_n   (rst_n),
        .pass_en (pass_en),
        .strobe  (strobe_a2b),
        .src     (a_pad_i),
        .held    (b_pad_o)
    );

    xcvr_store #(.WIDTH(WIDTH)) u_store_b2a (
        .clk     (clk),
        .rst_n   (rst_n),
        .pass_en (pass_en),
        .strobe  (strobe_b2a),
        .src     (b_pad_i),
        .held    (a_pad_o)
    );

    xcvr_drive_ctrl u_drive (
        .clk        (clk),
        .rst_n      (rst_n),
        .drive_en_n (drive_en_n),
        .dir_a2b    (dir_a2b),
        .drv_a      (drv_a),
        .drv_b      (drv_b)
    );

    for (genvar i = 0; i < WIDTH; i++) begin : g_pad_oe
        assign a_pad_oe[i] = drv_a;
        assign b_pad_oe[i] = drv_b;
    end

    // R7 / R6: the A-to-B register ignores the B-to-A strobe in capture mode
    a_r6_dir_indep: assert property (@(posedge clk) disable iff (!rst_n)
        (!pass_en && $stable(strobe_a2b)) |=> $stable(b_pad_o));

endmodule

// File: tb/bidir_xcvr_reg_tb_top.sv
module bidir_xcvr_reg_tb_top;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         drive_en_n = 1'b1;
    logic         dir_a2b = 1'b0;
    logic         pass_en = 1'b0;
    logic         strobe_a2b = 1'b0;
    logic         strobe_b2a = 1'b0;
    logic [W-1:0] a_pad_i = '0;
    logic [W-1:0] b_pad_i = '0;
    logic [W-1:0] a_pad_o, a_pad_oe, b_pad_o, b_pad_oe;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    bidir_xcvr_reg #(.WIDTH(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .drive_en_n(drive_en_n), .dir_a2b(dir_a2b),
        .pass_en(pass_en), .strobe_a2b(strobe_a2b), .strobe_b2a(strobe_b2a),
        .a_pad_i(a_pad_i), .a_pad_o(a_pad_o), .a_pad_oe(a_pad_oe),
        .b_pad_i(b_pad_i), .b_pad_o(b_pad_o), .b_pad_oe(b_pad_oe)
    );

    task automatic cyc();
        @(posedge clk);
        #2;
    endtask

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) cyc();
        chk("R9 a_pad_o", a_pad_o, 8'h00);
        chk("R9 b_pad_o", b_pad_o, 8'h00);
        chk("R9 a_pad_oe", a_pad_oe, 8'h00);
        chk("R9 b_pad_oe", b_pad_oe, 8'h00);
        rst_n = 1'b1;
        cyc();
    endtask

    task automatic t_isolate();
        drive_en_n = 1'b1; dir_a2b = 1'b1; pass_en = 1'b1; a_pad_i = 8'h3C;
        cyc();
        chk("R1 b_pad_oe", b_pad_oe, 8'h00);
        chk("R1 a_pad_oe", a_pad_oe, 8'h00);
        chk("R10 b_pad_o loads while isolated", b_pad_o, 8'h3C);
        dir_a2b = 1'b0;
        cyc();
        chk("R1 a_pad_oe dir0", a_pad_oe, 8'h00);
        chk("R1 b_pad_oe dir0", b_pad_oe, 8'h00);
        drive_en_n = 1'b0; dir_a2b = 1'b1; pass_en = 1'b0;
        cyc();
        chk("R10 value shown once driven", b_pad_o, 8'h3C);
    endtask

    task automatic t_direction();
        drive_en_n = 1'b0; dir_a2b = 1'b1;
        cyc();
        chk("R2 b_pad_oe dir1", b_pad_oe, 8'hFF);
        chk("R2 a_pad_oe dir1", a_pad_oe, 8'h00);
        dir_a2b = 1'b0;
        cyc();
        chk("R2 a_pad_oe dir0", a_pad_oe, 8'hFF);
        chk("R2 b_pad_oe dir0", b_pad_oe, 8'h00);
    endtask

    task automatic t_pass();
        dir_a2b = 1'b1; pass_en = 1'b1; a_pad_i = 8'hA5;
        cyc();
        chk("R3 R7 pass A5", b_pad_o, 8'hA5);
        a_pad_i = 8'h5A;
        cyc();
        chk("R3 R7 pass 5A", b_pad_o, 8'h5A);
    endtask

    task automatic t_hold();
        pass_en = 1'b1; strobe_a2b = 1'b0; a_pad_i = 8'h11;
        cyc();
        pass_en = 1'b0; a_pad_i = 8'h22;
        cyc(); cyc();
        chk("R4 hold static low", b_pad_o, 8'h11);
    endtask

    task automatic t_capture();
        pass_en = 1'b0; strobe_a2b = 1'b0; a_pad_i = 8'hC3;
        cyc();
        strobe_a2b = 1'b1;
        cyc();
        chk("R5 rising edge loads", b_pad_o, 8'hC3);
        a_pad_i = 8'h0F;
        cyc();
        chk("R4 static high holds", b_pad_o, 8'hC3);
        strobe_a2b = 1'b0;
        cyc();
        chk("R5 falling edge no load", b_pad_o, 8'hC3);
        strobe_a2b = 1'b1;
        cyc();
        chk("R5 second rising edge", b_pad_o, 8'h0F);
    endtask

    task automatic t_mode_drop_high();
        pass_en = 1'b1; strobe_a2b = 1'b1; a_pad_i = 8'h77;
        cyc();
        chk("R3 pass with strobe high", b_pad_o, 8'h77);
        pass_en = 1'b0; a_pad_i = 8'h88;
        cyc();
        chk("R8 keeps value at mode drop", b_pad_o, 8'h77);
        cyc();
        chk("R8 still held", b_pad_o, 8'h77);
    endtask

    task automatic t_b2a();
        dir_a2b = 1'b0; pass_en = 1'b1; b_pad_i = 8'h12;
        strobe_a2b = 1'b0; strobe_b2a = 1'b0;
        cyc();
        chk("R6 pass B to A", a_pad_o, 8'h12);
        pass_en = 1'b0; b_pad_i = 8'h96;
        cyc();
        strobe_a2b = 1'b1;
        cyc();
        chk("R6 other strobe ignored", a_pad_o, 8'h12);
        strobe_b2a = 1'b1;
        cyc();
        chk("R6 own strobe loads", a_pad_o, 8'h96);
        b_pad_i = 8'h69;
        cyc();
        chk("R6 static high holds", a_pad_o, 8'h96);
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        t_reset();
        t_isolate();
        t_direction();
        t_pass();
        t_hold();
        t_capture();
        t_mode_drop_high();
        t_b2a();
        done = 1'b1;
        summary();
    end

    initial begin
        #2000000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            summary();
        end
    end

endmodule